// File: doc/BRIEF.md
# I2C Slave Interface with Clock Stretching

This block is a 7-bit addressed I2C slave target. It synchronises the two bus lines to the system clock and finds START and STOP conditions and SCL edges. After each START it shifts in an address byte. The upper seven bits of that byte are compared with a programmable device address, and the last bit gives the transfer direction.

On a match, the block acknowledges by pulling SDA low and raises an interrupt. It then holds SCL low until the local host answers through a small data-register port. When the master reads, the host must write the next byte. When the master writes, the host must read the received byte. A read with nothing to use it for still counts.

The same interrupt also fires at the end of every data byte. The address-hit flag tells the host which of the two causes it is handling. Both bus outputs are open-drain pull-down enables and never drive a line high.

Top module: `i2cs_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both seen after a two-flop synchroniser. A STOP returns the block to idle, releases both lines and clears `addr_hit`.
- R2: After a START the block shifts in 8 bits, most significant first, on SCL rising edges. Bits 7..1 are compared with `own_addr`. On a match, `addr_hit` and `irq` go to 1 and `dir_rd` takes bit 0, where 1 means the master reads.
- R3: On an address match the block sets `sda_oe` to 1 (ACK, SDA low) for the whole 9th clock.
- R4: On an address mismatch, `addr_hit` is 0 and no ACK is driven. There is also no interrupt and no stretch, and all later bits are ignored until the next START.
- R5: At the falling SCL edge that ends any ACK slot the block sets `scl_oe` to 1. The line stays held until the matching host action: `host_wr` when `dir_rd` is 1, and `host_rd` when `dir_rd` is 0. The other action does not release the line.
- R6: In receive mode the block shifts in 8 data bits, most significant first. At the 8th rising edge it copies them to `host_rdata`, sets `irq` and clears `addr_hit`. In the following 9th clock it pulls SDA low if `tx_nak` is 0 and leaves SDA released if `tx_nak` is 1.
- R7: In transmit mode a `host_wr` loads `host_wdata`, and the block shifts it out most significant first, with `sda_oe` equal to the inverse of each bit. SDA is released in the 9th clock. At that clock's rising edge the block samples SDA into `rx_nack` (1 means NACK), sets `irq` and clears `addr_hit`. After an ACK it stretches again. After a NACK it releases both lines and waits for a STOP or START.
- R8: `irq` is a level. It clears on a `host_rd` or `host_wr` pulse, and a new interrupt in the same cycle wins. `host_wr` always updates `host_rdata`.
- R9: `sda_oe` changes only while SCL is low.
- R10: A repeated START in the middle of a transfer restarts the address phase with a fresh direction bit.
- R11: After reset every output is 0: both lines are released, all flags are clear and the data register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | ADDR_W | Device address to match |
| tx_nak | input | 1 | ACK value for received bytes: 0 ACK, 1 NACK |
| host_wr | input | 1 | Host write strobe for the data register |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe (releases a receive stretch) |
| host_rdata | output | DATA_W | Data register contents |
| irq | output | 1 | Interrupt level |
| addr_hit | output | 1 | Last interrupt came from an address match |
| dir_rd | output | 1 | 1: master reads, slave transmits |
| rx_nack | output | 1 | Acknowledge sampled from the master, 1 = NACK |

## Verification
The bench makes the wrong host action while the line is stretched. A design that releases SCL on any access would let the bus run before the data is ready. It ends a read with a master NACK, where a design that stretches anyway would hang the bus. It sends a mismatched address followed by a byte, which a careless design would acknowledge or capture. It also restarts in the middle of a receive, where a design that keeps its bit count would misread the next address and direction. The flags are compared with a behavioural model on every quiet clock, so an early `irq`, a stale `addr_hit` or a wrong `dir_rd` is caught in the cycle it appears.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ARM,
      ST_ACK_DRV,
      ST_WAIT_RX,
      ST_RX,
      ST_WAIT_TX,
      ST_TX,
      ST_TX_ACK
   } slv_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '1;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_bus_evt.sv
module i2cs_bus_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              tx_nak,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   output logic              addr_hit,
   output logic              dir_rd,
   output logic              rx_nack,
   output logic              scl_oe,
   output logic              sda_oe
);
   localparam int                CNT_W     = $clog2(DATA_W);
   localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);

   slv_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] full;
   logic              ack_low;
   logic              match;

   assign full  = {shreg[DATA_W-2:0], sda_s};
   assign match = (full[ADDR_W:1] == own_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         ack_low    <= 1'b0;
         host_rdata <= '0;
         irq        <= 1'b0;
         addr_hit   <= 1'b0;
         dir_rd     <= 1'b0;
         rx_nack    <= 1'b0;
         scl_oe     <= 1'b0;
         sda_oe     <= 1'b0;
      end else begin
         if (host_rd || host_wr) irq <= 1'b0;
         if (host_wr) host_rdata <= host_wdata;
         if (start_evt) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_evt) begin
            state    <= ST_IDLE;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            addr_hit <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: if (scl_rise) begin
                  shreg <= full;
                  if (cnt == ADDR_LAST) begin
                     if (match) begin
                        addr_hit <= 1'b1;
                        dir_rd   <= full[0];
                        irq      <= 1'b1;
                        ack_low  <= 1'b1;
                        state    <= ST_ACK_ARM;
                     end else begin
                        addr_hit <= 1'b0;
                        state    <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ACK_ARM: if (scl_fall) begin
                  sda_oe <= ack_low;
                  state  <= ST_ACK_DRV;
               end
               ST_ACK_DRV: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  scl_oe <= 1'b1;
                  state  <= dir_rd ? ST_WAIT_TX : ST_WAIT_RX;
               end
               ST_WAIT_RX: if (host_rd) begin
                  scl_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_RX;
               end
               ST_RX: if (scl_rise) begin
                  shreg <= full;
                  if (cnt == DATA_LAST) begin
                     host_rdata <= full;
                     irq        <= 1'b1;
                     addr_hit   <= 1'b0;
                     ack_low    <= ~tx_nak;
                     state      <= ST_ACK_ARM;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WAIT_TX: if (host_wr) begin
                  shreg  <= host_wdata;
                  sda_oe <= ~host_wdata[DATA_W-1];
                  scl_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_TX;
               end
               ST_TX: if (scl_fall) begin
                  if (cnt == DATA_LAST) begin
                     sda_oe <= 1'b0;
                     state  <= ST_TX_ACK;
                  end else begin
                     sda_oe <= ~shreg[DATA_W-2];
                     shreg  <= shreg << 1;
                     cnt    <= cnt + 1'b1;
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     rx_nack  <= sda_s;
                     irq      <= 1'b1;
                     addr_hit <= 1'b0;
                  end
                  if (scl_fall) begin
                     if (rx_nack) begin
                        state <= ST_IDLE;
                     end else begin
                        scl_oe <= 1'b1;
                        state  <= ST_WAIT_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              tx_nak,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   output logic              addr_hit,
   output logic              dir_rd,
   output logic              rx_nack
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2cs_slave: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W + 1 > DATA_W) begin : g_bad_addr
      $error("i2cs_slave: address plus direction bit must fit in DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("i2cs_slave: DATA_W must be at least 2");
   end

   logic [1:0] lines_s;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_evt, stop_evt;

   i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (lines_s)
   );
   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   i2cs_bus_evt u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_evt  (start_evt),
      .stop_evt   (stop_evt),
      .sda_s      (sda_s),
      .own_addr   (own_addr),
      .tx_nak     (tx_nak),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rd    (host_rd),
      .host_rdata (host_rdata),
      .irq        (irq),
      .addr_hit   (addr_hit),
      .dir_rd     (dir_rd),
      .rx_nack    (rx_nack),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe)
   );
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_evt,
   input logic stop_evt,
   input logic host_rd,
   input logic host_wr,
   input logic scl_oe,
   input logic sda_oe,
   input logic irq,
   input logic addr_hit
);
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!addr_hit && !scl_oe && !sda_oe)); // R1
   AST_HIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_hit) |-> irq); // R2
   AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && !host_rd && !host_wr) |=> scl_oe); // R5
   AST_RELEASE_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |-> $past(host_rd || host_wr)); // R5
   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s)); // R9
   AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .host_rd   (host_rd),
   .host_wr   (host_wr),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .irq       (irq),
   .addr_hit  (addr_hit)
);

// File: tb/sim_i2cs_slave.sv
module sim_i2cs_slave;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 10;
   localparam int WD_LIMIT   = 150000;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic m_scl_oe = 1'b0, m_sda_oe = 1'b0;
   logic scl_oe, sda_oe;
   logic scl_line, sda_line;
   assign scl_line = ~(m_scl_oe | scl_oe);
   assign sda_line = ~(m_sda_oe | sda_oe);

   logic       tx_nak = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       irq, addr_hit, dir_rd, rx_nack;

   i2cs_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .tx_nak(tx_nak),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .irq(irq), .addr_hit(addr_hit),
      .dir_rd(dir_rd), .rx_nack(rx_nack)
   );

   int tests = 0, fails = 0, cyc = 0;
   // behavioural model of the flags
   logic       m_irq = 0, m_hit = 0, m_dir = 0, m_nack = 0;
   logic [7:0] m_data = '0;
   logic       pend_dir = 0, pend_nack = 0;
   logic [7:0] pend_data = '0;
   int quiet = 0;
   logic scl_q = 1, sda_q = 1;
   int sda_oe_cycles = 0, scl_oe_cycles = 0, sda_bad_moves = 0;
   logic sda_oe_prev = 0;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (scl_line != scl_q || sda_line != sda_q || host_rd || host_wr) quiet <= 0;
      else if (quiet < 15) quiet <= quiet + 1;
      scl_q <= scl_line;
      sda_q <= sda_line;
      if (sda_oe) sda_oe_cycles++;
      if (scl_oe) scl_oe_cycles++;
      if (cyc == WD_LIMIT) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // per-clock comparison against the model, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe != sda_oe_prev && scl_line) sda_bad_moves++;
         sda_oe_prev = sda_oe;
         if (quiet >= 4 && scl_line == scl_q && sda_line == sda_q && !host_rd && !host_wr) begin
            chk(irq == m_irq, "R8 irq", irq, m_irq);
            chk(addr_hit == m_hit, "R2 addr_hit", addr_hit, m_hit);
            chk(dir_rd == m_dir, "R2 dir_rd", dir_rd, m_dir);
            chk(rx_nack == m_nack, "R7 rx_nack", rx_nack, m_nack);
            chk(host_rdata == m_data, "R6 host_rdata", host_rdata, m_data);
         end
      end
   end

   task automatic apply(input int kind);
      case (kind)
         1: begin m_irq = 1; m_hit = 1; m_dir = pend_dir; end
         2: m_hit = 0;
         3: begin m_irq = 1; m_hit = 0; m_data = pend_data; end
         4: begin m_irq = 1; m_hit = 0; m_nack = pend_nack; end
         default: ;
      endcase
   endtask

   task automatic bit_clk(input logic b, input int kind, output logic smp);
      m_sda_oe = ~b;
      repeat (H/2) @(negedge clk);
      m_scl_oe = 1'b0;
      while (!scl_line) @(negedge clk);
      apply(kind);
      repeat (H) @(negedge clk);
      smp = sda_line;
      m_scl_oe = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda_oe = 1'b0;
      repeat (H) @(negedge clk);
      m_scl_oe = 1'b0;
      while (!scl_line) @(negedge clk);
      repeat (H) @(negedge clk);
      m_sda_oe = 1'b1;
      repeat (H) @(negedge clk);
      m_scl_oe = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_stop();
      m_sda_oe = 1'b1;
      repeat (H) @(negedge clk);
      m_scl_oe = 1'b0;
      while (!scl_line) @(negedge clk);
      repeat (H) @(negedge clk);
      m_sda_oe = 1'b0;
      m_hit = 0;
      repeat (2*H) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, input int kind, output logic ack);
      logic t;
      for (int i = 7; i >= 0; i--) bit_clk(v[i], (i == 0) ? kind : 0, t);
      bit_clk(1'b1, 0, ack);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic mack);
      logic t;
      for (int i = 7; i >= 0; i--) begin
         bit_clk(1'b1, 0, t);
         v[i] = t;
      end
      pend_nack = mack;
      bit_clk(mack, 4, t);
   endtask

   task automatic do_rd();
      @(negedge clk); host_rd = 1'b1; m_irq = 0;
      @(negedge clk); host_rd = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_wr(input logic [7:0] v);
      @(negedge clk); host_wr = 1'b1; host_wdata = v; m_irq = 0; m_data = v;
      @(negedge clk); host_wr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      logic       ack;
      logic [7:0] v;
      int         s0, c0;
      repeat (4) @(negedge clk);
      // R11: reset state
      chk({scl_oe, sda_oe, irq, addr_hit, dir_rd, rx_nack} == 6'b0, "R11 flags after reset",
          {scl_oe, sda_oe, irq, addr_hit, dir_rd, rx_nack}, 0);
      chk(host_rdata == 8'h00, "R11 data after reset", host_rdata, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // master write transfer
      bus_start();
      pend_dir = 1'b0;
      send_byte({OWN, 1'b0}, 1, ack);
      chk(ack == 1'b0, "R3 address ack", ack, 0);
      chk(addr_hit && irq && !dir_rd, "R2 match flags", {addr_hit, irq, dir_rd}, 3'b110);
      chk(scl_oe == 1'b1, "R5 stretch after address", scl_oe, 1);
      do_wr(8'h11);
      repeat (6) @(negedge clk);
      chk(scl_oe == 1'b1, "R5 write does not release receive stretch", scl_oe, 1);
      chk(irq == 1'b0, "R8 irq cleared by host access", irq, 0);
      do_rd();
      chk(scl_oe == 1'b0, "R5 read releases receive stretch", scl_oe, 0);
      tx_nak = 1'b0;
      pend_data = 8'hA7;
      send_byte(8'hA7, 3, ack);
      chk(ack == 1'b0, "R6 ack on received byte", ack, 0);
      chk(host_rdata == 8'hA7 && !addr_hit, "R6 byte captured", host_rdata, 8'hA7);
      chk(scl_oe == 1'b1, "R5 stretch after data byte", scl_oe, 1);
      do_rd();
      tx_nak = 1'b1;
      pend_data = 8'h3C;
      send_byte(8'h3C, 3, ack);
      chk(ack == 1'b1, "R6 nack from tx_nak", ack, 1);
      chk(host_rdata == 8'h3C, "R6 second byte", host_rdata, 8'h3C);
      do_rd();
      bus_stop();
      chk(!scl_oe && !sda_oe && !addr_hit, "R1 stop releases", {scl_oe, sda_oe, addr_hit}, 0);
      tx_nak = 1'b0;

      // master read transfer
      bus_start();
      pend_dir = 1'b1;
      send_byte({OWN, 1'b1}, 1, ack);
      chk(ack == 1'b0 && dir_rd, "R2 read direction", {ack, dir_rd}, 2'b01);
      do_rd();
      repeat (6) @(negedge clk);
      chk(scl_oe == 1'b1, "R5 read does not release transmit stretch", scl_oe, 1);
      do_wr(8'hC5);
      chk(scl_oe == 1'b0, "R5 write releases transmit stretch", scl_oe, 0);
      recv_byte(v, 1'b0);
      chk(v == 8'hC5, "R7 transmitted byte", v, 8'hC5);
      chk(rx_nack == 1'b0 && irq && scl_oe, "R7 ack sampled, stretch again",
          {rx_nack, irq, scl_oe}, 3'b011);
      do_wr(8'h81);
      recv_byte(v, 1'b1);
      chk(v == 8'h81, "R7 second transmitted byte", v, 8'h81);
      chk(rx_nack == 1'b1, "R7 nack sampled", rx_nack, 1);
      repeat (H) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 no stretch after nack", {scl_oe, sda_oe}, 0);
      bus_stop();

      // repeated start in the middle of a receive
      bus_start();
      pend_dir = 1'b0;
      send_byte({OWN, 1'b0}, 1, ack);
      do_rd();
      pend_data = 8'h96;
      send_byte(8'h96, 3, ack);
      do_rd();
      bus_start();
      pend_dir = 1'b1;
      send_byte({OWN, 1'b1}, 1, ack);
      chk(ack == 1'b0 && dir_rd && addr_hit, "R10 repeated start re-addresses",
          {ack, dir_rd, addr_hit}, 3'b011);
      do_wr(8'h0F);
      recv_byte(v, 1'b1);
      chk(v == 8'h0F, "R10 byte after repeated start", v, 8'h0F);
      bus_stop();

      // address mismatch
      do_rd();
      s0 = sda_oe_cycles;
      c0 = scl_oe_cycles;
      bus_start();
      send_byte({7'h33, 1'b0}, 2, ack);
      chk(ack == 1'b1, "R4 no ack on mismatch", ack, 1);
      send_byte(8'h00, 0, ack);
      chk(ack == 1'b1, "R4 later byte ignored", ack, 1);
      chk(sda_oe_cycles == s0 && scl_oe_cycles == c0, "R4 lines untouched",
          sda_oe_cycles - s0 + scl_oe_cycles - c0, 0);
      chk(!irq && !addr_hit && host_rdata == 8'h0F, "R4 flags and data unchanged",
          {irq, addr_hit, host_rdata}, {2'b00, 8'h0F});
      bus_stop();

      chk(sda_bad_moves == 0, "R9 SDA moves only with SCL low", sda_bad_moves, 0);
      repeat (10) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule